// File: doc/BRIEF.md
# Recency-Position Dead-Line Predictor

This block watches the hit traffic of a set-associative last-level cache with LRU replacement. It works out which recency positions hold lines that are unlikely to be referenced again before they are evicted. The unit of prediction is the position in the recency stack, not the individual line. Position 0 is the most recently used way and position `WAYS-1` is the least recently used way. There is one saturating hit counter for each position and one saturating counter for all accesses. A fixed-length time window, the slice, bounds the counting.

When a slice closes, the counts are frozen into a snapshot and the live counters restart from zero. A small state machine then walks the snapshot from the LRU end, one position per cycle, adding hit counts for as long as the running sum stays strictly below one thirty-second of the slice's total accesses. The length of that run decides the published boundary `dead_from`. Every position numbered `dead_from` or higher counts as useless until the next boundary is published. The old boundary stays in force while the walk runs.

The write-back side of the cache presents a line's recency position and dirty bit on the query port. `qry_cand` tells it whether that line should be offered for an early, slow write-back.

The state machine has three states:
- **IDLE_COUNT**: counting, waiting for the slice end.
- **WALK**: accumulating one position per cycle.
- **PUBLISH**: loading the new boundary.

It has four transitions:
- **slice_close** (IDLE_COUNT to WALK): taken on the last cycle of a slice.
- **walk_step** (WALK to WALK): taken while the next position still fits under the limit.
- **walk_stop** (WALK to PUBLISH): taken at the first position that would reach the limit, or once all ways are taken.
- **publish_done** (PUBLISH to IDLE_COUNT): taken unconditionally.

Top module: `dlp_dead_predictor`

## Requirements
- R1: After reset, `dead_from` equals `WAYS` (no position useless) and `qry_cand` is 0.
- R2: An access cycle (`acc_valid`=1) adds one to the total-access count. When `acc_hit`=1 as well, it also adds one to the hit count of position `acc_pos`, where 0 is MRU and `WAYS-1` is LRU. A miss (`acc_hit`=0) adds to the total only.
- R3: A slice is exactly `SLICE_CYCLES` clock cycles long. The first slice starts at the first clock edge after reset is released.
- R4: At slice close, the block counts k, the longest run of positions starting at position `WAYS-1` and moving toward 0 whose summed hit counts are strictly less than the slice total shifted right by 5 bits. The walk stops at the first position that fails. The published value is `dead_from = WAYS - k`.
- R5: The new `dead_from` appears at the clock edge k+2 edges after the slice-closing edge. Until then the previous value is held.
- R6: All counters restart from zero at each slice boundary. An access in the slice's last cycle belongs to the slice that is closing.
- R7: The hit counters and the total counter saturate at `2^CNT_W-1` instead of wrapping.
- R8: A slice with no accesses publishes `WAYS` (limit 0). A slice with only misses and a total of at least 32 publishes 0 (all ways useless).
- R9: `qry_cand` is 1 exactly when `qry_dirty`=1 and `qry_pos >= dead_from`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One cache access this cycle |
| acc_hit | input | 1 | The access hit |
| acc_pos | input | $clog2(WAYS) | Recency position of the hit, 0 = MRU |
| qry_pos | input | $clog2(WAYS) | Recency position of the line being queried |
| qry_dirty | input | 1 | The queried line is dirty |
| dead_from | output | $clog2(WAYS+1) | First useless position; `WAYS` means none |
| qry_cand | output | 1 | The queried line is an early write-back candidate |

## Verification
The bench goes after the following corner cases. Each is followed by what a faulty design would do.

- **Strict less-than at the limit.** A `<=` comparison would take one position too many whenever a prefix sum lands exactly on the limit.
- **Empty slice and all-miss slice.** These hit the extremes of none and all. A walk that does not stop at `WAYS` would index past the stack.
- **Saturating totals.** A wrapping counter shrinks the limit and publishes a boundary that is far too conservative.
- **Accesses in the closing cycle.** These would be lost or leaked into the next slice if the snapshot and the clear were out of step.
- **Publish timing and holding the old value.** The per-cycle model catches a boundary that changes early, changes late, or flickers through intermediate values during the walk.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE_COUNT = 2'd0,
        ST_WALK       = 2'd1,
        ST_PUBLISH    = 2'd2
    } dlp_state_e;

    localparam int unsigned LIMIT_SHIFT = 5;

endpackage

// File: rtl/dlp_slice_timer.sv
module dlp_slice_timer #(
    parameter int unsigned SLICE_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic slice_end
);
    localparam int unsigned TCW = (SLICE_CYCLES > 1) ? $clog2(SLICE_CYCLES) : 1;
    localparam logic [TCW-1:0] LAST = TCW'(SLICE_CYCLES - 1);

    logic [TCW-1:0] tick_q;

    assign slice_end = (tick_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (slice_end) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/dlp_hit_bank.sv
module dlp_hit_bank #(
    parameter int unsigned WAYS  = 16,
    parameter int unsigned CNT_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic                     acc_hit,
    input  logic [$clog2(WAYS)-1:0]  acc_pos,
    input  logic                     slice_end,
    input  logic [$clog2(WAYS)-1:0]  sel_pos,
    output logic [CNT_W-1:0]         sel_cnt,
    output logic [CNT_W-1:0]         snap_total
);
    localparam int unsigned PW = $clog2(WAYS);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [WAYS-1:0][CNT_W-1:0] snap_vec;
    logic [CNT_W-1:0]           tot_live_q;
    logic [CNT_W-1:0]           tot_next;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [CNT_W-1:0] live_q;
        logic [CNT_W-1:0] frozen_q;
        logic [CNT_W-1:0] live_next;
        logic             bump;

        assign bump      = acc_valid && acc_hit && (acc_pos == PW'(g));
        assign live_next = (bump && (live_q != CMAX)) ? live_q + 1'b1 : live_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q   <= '0;
                frozen_q <= '0;
            end else if (slice_end) begin
                frozen_q <= live_next;
                live_q   <= '0;
            end else begin
                live_q   <= live_next;
            end
        end

        assign snap_vec[g] = frozen_q;
    end

    assign tot_next = (acc_valid && (tot_live_q != CMAX)) ? tot_live_q + 1'b1 : tot_live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot_live_q <= '0;
            snap_total <= '0;
        end else if (slice_end) begin
            snap_total <= tot_next;
            tot_live_q <= '0;
        end else begin
            tot_live_q <= tot_next;
        end
    end

    assign sel_cnt = snap_vec[sel_pos];
endmodule

// File: rtl/dlp_dead_predictor.sv
module dlp_dead_predictor
    import dlp_pkg::*;
#(
    parameter int unsigned WAYS         = 16,
    parameter int unsigned SLICE_CYCLES = 500000,
    parameter int unsigned CNT_W        = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid,
    input  logic                          acc_hit,
    input  logic [$clog2(WAYS)-1:0]       acc_pos,
    input  logic [$clog2(WAYS)-1:0]       qry_pos,
    input  logic                          qry_dirty,
    output logic [$clog2(WAYS+1)-1:0]     dead_from,
    output logic                          qry_cand
);
    localparam int unsigned PW = $clog2(WAYS);
    localparam int unsigned TW = $clog2(WAYS + 1);
    localparam int unsigned SW = CNT_W + TW;
    localparam logic [PW-1:0] LRU_POS  = PW'(WAYS - 1);
    localparam logic [TW-1:0] ALL_WAYS = TW'(WAYS);

    logic             slice_end;
    logic [PW-1:0]    sel_pos;
    logic [CNT_W-1:0] sel_cnt;
    logic [CNT_W-1:0] snap_total;

    dlp_slice_timer #(.SLICE_CYCLES(SLICE_CYCLES)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slice_end (slice_end)
    );

    dlp_hit_bank #(.WAYS(WAYS), .CNT_W(CNT_W)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_hit    (acc_hit),
        .acc_pos    (acc_pos),
        .slice_end  (slice_end),
        .sel_pos    (sel_pos),
        .sel_cnt    (sel_cnt),
        .snap_total (snap_total)
    );

    dlp_state_e    state_q, state_d;
    logic [TW-1:0] walk_k_q;
    logic [SW-1:0] walk_sum_q;
    logic [SW-1:0] trial_sum;
    logic [SW-1:0] walk_limit;
    logic          walk_take;

    // The walk starts at the LRU end and moves toward MRU.
    assign sel_pos    = LRU_POS - walk_k_q[PW-1:0];
    assign trial_sum  = walk_sum_q + SW'(sel_cnt);
    assign walk_limit = SW'(snap_total >> LIMIT_SHIFT);
    assign walk_take  = (walk_k_q != ALL_WAYS) && (trial_sum < walk_limit);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: slice_close, walk_step, walk_stop, publish_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE_COUNT: if (slice_end) state_d = ST_WALK;
            ST_WALK:       if (!walk_take) state_d = ST_PUBLISH;
            ST_PUBLISH:    state_d = ST_IDLE_COUNT;
            default:       state_d = ST_IDLE_COUNT;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_k_q   <= '0;
            walk_sum_q <= '0;
        end else if (state_q == ST_IDLE_COUNT && slice_end) begin
            walk_k_q   <= '0;
            walk_sum_q <= '0;
        end else if (state_q == ST_WALK && walk_take) begin
            walk_k_q   <= walk_k_q + 1'b1;
            walk_sum_q <= trial_sum;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dead_from <= ALL_WAYS;
        end else if (state_q == ST_PUBLISH) begin
            dead_from <= ALL_WAYS - walk_k_q;
        end
    end

    assign qry_cand = qry_dirty && (TW'(qry_pos) >= dead_from);
endmodule

// File: rtl/dlp_dead_predictor_chk.sv
module dlp_dead_predictor_chk
    import dlp_pkg::*;
#(
    parameter int unsigned WAYS         = 16,
    parameter int unsigned SLICE_CYCLES = 500000,
    parameter int unsigned CNT_W        = 20
) (
    input logic                          clk,
    input logic                          rst_n,
    input dlp_state_e                    state_q,
    input logic                          slice_end,
    input logic [CNT_W+$clog2(WAYS+1)-1:0] walk_sum_q,
    input logic [CNT_W+$clog2(WAYS+1)-1:0] walk_limit,
    input logic [$clog2(WAYS+1)-1:0]     dead_from,
    input logic [$clog2(WAYS)-1:0]       qry_pos,
    input logic                          qry_dirty,
    input logic                          qry_cand
);
    localparam int unsigned PW = $clog2(WAYS);

    // R5: the walk must finish before the next slice closes
    initial begin
        slice_len_chk: assert (SLICE_CYCLES > WAYS + 2);
    end

    // R5
    dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_from != $past(dead_from)) |-> ($past(state_q) == ST_PUBLISH));

    // R3
    slice_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_end && state_q == ST_IDLE_COUNT) |=> (state_q == ST_WALK));

    // R5
    publish_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUBLISH) |=> (state_q == ST_IDLE_COUNT));

    // R4
    scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WALK) |-> (walk_sum_q == '0 || walk_sum_q < walk_limit));

    // R8
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dead_from <= ($clog2(WAYS+1))'(WAYS));

    // R9
    cand_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_cand |-> qry_dirty);

    // R9
    cand_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_dirty && qry_pos == PW'(WAYS - 1) && dead_from < ($clog2(WAYS+1))'(WAYS)) |-> qry_cand);
endmodule

bind dlp_dead_predictor dlp_dead_predictor_chk #(
    .WAYS(WAYS), .SLICE_CYCLES(SLICE_CYCLES), .CNT_W(CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .slice_end  (slice_end),
    .walk_sum_q (walk_sum_q),
    .walk_limit (walk_limit),
    .dead_from  (dead_from),
    .qry_pos    (qry_pos),
    .qry_dirty  (qry_dirty),
    .qry_cand   (qry_cand)
);

// File: tb/dlp_dead_predictor_tb.sv
`timescale 1ns/100ps
module dlp_dead_predictor_tb_top;
    localparam int WAYS  = 8;
    localparam int SLICE = 160;
    localparam int CW    = 7;
    localparam int CMAX  = (1 << CW) - 1;
    localparam int PW    = $clog2(WAYS);
    localparam int TW    = $clog2(WAYS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_hit = 1'b0;
    logic [PW-1:0] acc_pos = '0;
    logic [PW-1:0] qry_pos = '0;
    logic          qry_dirty = 1'b0;
    logic [TW-1:0] dead_from;
    logic          qry_cand;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cnt[WAYS];
    int m_tot;
    int m_tick;
    int m_pend;
    int m_next_dead;
    int m_dead;

    always #2.5 clk = ~clk;

    dlp_dead_predictor #(.WAYS(WAYS), .SLICE_CYCLES(SLICE), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_pos(acc_pos), .qry_pos(qry_pos), .qry_dirty(qry_dirty),
        .dead_from(dead_from), .qry_cand(qry_cand)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < WAYS; i++) m_cnt[i] = 0;
        m_tot = 0; m_tick = 0; m_pend = 0; m_next_dead = WAYS; m_dead = WAYS;
    endtask

    // advance the model by one edge using the inputs presented now
    task automatic model_step();
        int lim, sum, k;
        if (m_pend > 0) begin
            m_pend--;
            if (m_pend == 0) m_dead = m_next_dead;
        end
        if (acc_valid) begin
            if (m_tot < CMAX) m_tot++;
            if (acc_hit && m_cnt[acc_pos] < CMAX) m_cnt[acc_pos]++;
        end
        if (m_tick == SLICE - 1) begin
            lim = m_tot >> 5; sum = 0; k = 0;
            while (k < WAYS && (sum + m_cnt[WAYS-1-k]) < lim) begin
                sum += m_cnt[WAYS-1-k];
                k++;
            end
            m_next_dead = WAYS - k;
            m_pend = k + 2;
            for (int i = 0; i < WAYS; i++) m_cnt[i] = 0;
            m_tot = 0;
            m_tick = 0;
        end else begin
            m_tick++;
        end
    endtask

    task automatic cycle(input string tag);
        model_step();
        @(posedge clk);
        #1;
        check(tag, "dead_from", int'(dead_from), m_dead);
        check(tag, "qry_cand", int'(qry_cand), (qry_dirty && int'(qry_pos) >= m_dead) ? 1 : 0);
    endtask

    // mode: 0 idle, 1 misses only, 2 MRU hits, 3 random skew, 4 sparse LRU hits
    task automatic run(input string tag, input int mode, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            qry_pos   = PW'($urandom_range(0, WAYS - 1));
            qry_dirty = 1'($urandom_range(0, 1));
            unique case (mode)
                0: begin acc_valid = 1'b0; acc_hit = 1'b0; acc_pos = '0; end
                1: begin acc_valid = 1'b1; acc_hit = 1'b0; acc_pos = PW'($urandom_range(0, WAYS-1)); end
                2: begin acc_valid = 1'b1; acc_hit = 1'b1; acc_pos = '0; end
                3: begin
                    acc_valid = ($urandom_range(0, 9) < 8);
                    acc_hit   = ($urandom_range(0, 9) < 7);
                    acc_pos   = ($urandom_range(0, 19) == 0) ? PW'($urandom_range(0, WAYS-1))
                                                             : PW'($urandom_range(0, 2));
                end
                default: begin
                    acc_valid = 1'b1;
                    acc_hit   = ($urandom_range(0, 49) == 0);
                    acc_pos   = PW'($urandom_range(WAYS/2, WAYS-1));
                end
            endcase
            cycle(tag);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(17));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "dead_from", int'(dead_from), WAYS);
        qry_dirty = 1'b1; qry_pos = PW'(WAYS - 1);
        #1;
        check("R1", "qry_cand", int'(qry_cand), 0);
        rst_n = 1'b1;
        // R8: empty slice keeps none, then all-miss slice marks everything
        run("R8", 0, SLICE);
        run("R8", 1, SLICE);
        run("R5", 0, SLICE);
        // R7: saturating counters, MRU-only hits
        run("R7", 2, SLICE);
        run("R7", 0, SLICE);
        // R2: sparse hits near LRU among misses
        run("R2", 4, 3 * SLICE);
        // R4: skewed random traffic
        run("R4", 3, 6 * SLICE);
        // R6: traffic across boundaries with mode changes mid-slice
        run("R6", 1, SLICE / 2);
        run("R6", 4, SLICE);
        run("R6", 2, SLICE / 2 + 7);
        run("R3", 3, 2 * SLICE);
        run("R9", 4, 2 * SLICE);
        run("R5", 0, SLICE);
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule